// File: doc/BRIEF.md
# Packed Lane-Wise Integer Multiplier

This block multiplies two 128-bit operand vectors lane by lane for a vector integer datapath. A size code chooses 16-, 32- or 64-bit lanes. An operation code chooses which part of each product is returned. The low-product operation keeps the bottom N bits of each 2N-bit product. The two high-product operations keep the top N bits, with the operands read as unsigned or as two's-complement. The widening operation multiplies only the even-indexed lanes, as unsigned values, and writes each 2N-bit product into the space of two adjacent N-bit lanes.

Operands enter through a valid/ready handshake and leave through another after a fixed three-stage pipeline. The pipeline moves only while the downstream ready is high; when ready is low, every stage holds, including empty stages. A 64-bit lane product is built from 32-bit digit products. Only its low 64 bits are kept. Any size/operation pair that is not supported returns an all-zero vector with an error flag for that transfer.

Top module: `lmul_unit`

## Requirements
- R1: With size code 0 (16-bit lanes) or 1 (32-bit lanes) and operation code 0, each lane i of `out_data` holds the low N bits of the product of lane i of `in_a` and lane i of `in_b`. Lane i occupies bits [i*N+N-1 : i*N].
- R2: With size code 2 (64-bit lanes) and operation code 0, each of the two 64-bit lanes holds the product modulo 2^64 of the corresponding operand lanes.
- R3: With size code 0 or 1 and operation code 1, each lane holds the upper N bits of the unsigned 2N-bit product.
- R4: With size code 0 or 1 and operation code 2, each lane holds the upper N bits of the signed 2N-bit product, with both operand lanes read as two's complement.
- R5: With size code 0 or 1 and operation code 3, bits [j*2N+2N-1 : j*2N] hold the full unsigned product of operand lanes 2j. The odd-indexed operand lanes have no effect on the result.
- R6: Size code 3 with any operation, and size code 2 with operation codes 1 to 3, produce an all-zero `out_data` with `out_err` high. Every other combination gives `out_err` low.
- R7: Suppose a transfer is accepted at clock edge k and `out_ready` is high at edges k+1 and k+2. Then `out_valid` is high after edge k+2 and carries that transfer's result. Results leave in the order the transfers were accepted, and none is lost or duplicated.
- R8: `in_ready` equals `out_ready`. While `out_ready` is low, `out_valid`, `out_data` and `out_err` hold their values across the clock edge.
- R9: While `rst` is high and in the cycle after it falls, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand transfer offered |
| in_ready | output | 1 | Operand transfer can be taken this cycle |
| in_a | input | 128 | First operand vector |
| in_b | input | 128 | Second operand vector |
| in_size | input | 2 | Lane size: 0=16, 1=32, 2=64, 3=reserved |
| in_op | input | 2 | 0=low, 1=high unsigned, 2=high signed, 3=widening |
| out_valid | output | 1 | Result transfer offered |
| out_ready | input | 1 | Downstream takes the result; low stalls the whole pipeline |
| out_data | output | 128 | Result vector |
| out_err | output | 1 | The transfer used an unsupported size/operation pair |

## Verification
The embedded properties assume that `out_ready` is driven to a known level in every cycle from reset onward. The latency and bubble properties also assume that `in_valid` is never unknown while ready is high. The bench drives both signals from time zero, changes them only just after a rising edge, and holds each offered operand set stable until it is accepted. The random stream mixes reserved size codes and unsupported operations with the legal ones, so that the error path is exercised under stalls as well as the arithmetic.

// File: rtl/lmul_pkg.sv
package lmul_pkg;

    typedef enum logic [1:0] {
        SZ_16  = 2'd0,
        SZ_32  = 2'd1,
        SZ_64  = 2'd2,
        SZ_RSV = 2'd3
    } lmul_size_e;

    typedef enum logic [1:0] {
        OP_LOW    = 2'd0,
        OP_HIGH_U = 2'd1,
        OP_HIGH_S = 2'd2,
        OP_WIDEN  = 2'd3
    } lmul_op_e;

    function automatic logic lmul_legal(input lmul_size_e sz, input lmul_op_e op);
        logic ok;
        unique case (sz)
            SZ_16, SZ_32: ok = 1'b1;
            SZ_64:        ok = (op == OP_LOW);
            SZ_RSV:       ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/lmul_lane_array.sv
module lmul_lane_array #(
    parameter int VEC_W = 128,
    parameter int LW    = 16
) (
    input  logic [VEC_W-1:0]   a,
    input  logic [VEC_W-1:0]   b,
    input  logic               sgn,
    output logic [2*VEC_W-1:0] prod
);
    localparam int NL = VEC_W / LW;
    localparam int PW = 2 * LW;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LW-1:0]        la, lb;
        logic signed [PW-1:0] xa, xb;
        logic [PW-1:0]        p;

        assign la = a[i*LW +: LW];
        assign lb = b[i*LW +: LW];
        // extend to the product width so the low 2N bits of the multiply are exact
        assign xa = {{LW{sgn & la[LW-1]}}, la};
        assign xb = {{LW{sgn & lb[LW-1]}}, lb};
        assign p  = xa * xb;
        assign prod[i*PW +: PW] = p;
    end

endmodule

// File: rtl/lmul_digit64.sv
module lmul_digit64 #(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    output logic [VEC_W-1:0] prod
);
    localparam int NL = VEC_W / 64;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [31:0] a_lo, a_hi, b_lo, b_hi;
        logic [63:0] ll;
        logic [31:0] c1, c2;

        assign a_lo = a[i*64 +: 32];
        assign a_hi = a[i*64+32 +: 32];
        assign b_lo = b[i*64 +: 32];
        assign b_hi = b[i*64+32 +: 32];
        // base-2^32 digits: hi*hi lands above bit 63, the cross terms only need 32 bits
        assign ll = {32'd0, a_lo} * {32'd0, b_lo};
        assign c1 = a_lo * b_hi;
        assign c2 = a_hi * b_lo;
        assign prod[i*64 +: 64] = ll + {c1 + c2, 32'd0};
    end

endmodule

// File: rtl/lmul_select.sv
module lmul_select
    import lmul_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  lmul_size_e         size,
    input  lmul_op_e           op,
    input  logic               err,
    input  logic [2*VEC_W-1:0] p16,
    input  logic [2*VEC_W-1:0] p32,
    input  logic [VEC_W-1:0]   p64,
    output logic [VEC_W-1:0]   data
);
    logic [VEC_W-1:0] low_r  [2];
    logic [VEC_W-1:0] high_r [2];
    logic [VEC_W-1:0] wide_r [2];

    for (genvar s = 0; s < 2; s++) begin : g_size
        localparam int LW = 16 << s;
        localparam int NL = VEC_W / LW;
        localparam int PW = 2 * LW;
        logic [2*VEC_W-1:0] pv;
        assign pv = (s == 0) ? p16 : p32;

        for (genvar i = 0; i < NL; i++) begin : g_half
            assign low_r[s][i*LW +: LW]  = pv[i*PW +: LW];
            assign high_r[s][i*LW +: LW] = pv[i*PW+LW +: LW];
        end
        for (genvar j = 0; j < NL / 2; j++) begin : g_wide
            assign wide_r[s][j*PW +: PW] = pv[(2*j)*PW +: PW];
        end
    end

    always_comb begin
        data = '0;
        if (!err) begin
            unique case (size)
                SZ_16, SZ_32: begin
                    unique case (op)
                        OP_LOW:               data = low_r[size == SZ_32];
                        OP_HIGH_U, OP_HIGH_S: data = high_r[size == SZ_32];
                        OP_WIDEN:             data = wide_r[size == SZ_32];
                    endcase
                end
                SZ_64:  data = p64;
                SZ_RSV: data = '0;
            endcase
        end
    end

endmodule

// File: rtl/lmul_unit.sv
module lmul_unit
    import lmul_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VEC_W-1:0] in_a,
    input  logic [VEC_W-1:0] in_b,
    input  logic [1:0]       in_size,
    input  logic [1:0]       in_op,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_data,
    output logic             out_err
);
    localparam int PW = 2 * VEC_W;

    logic adv;
    assign adv      = out_ready;
    assign in_ready = out_ready;

    // stage 1: captured operands and decode
    logic             s1_valid, s1_err;
    logic [VEC_W-1:0] s1_a, s1_b;
    lmul_size_e       s1_size;
    lmul_op_e         s1_op;

    // stage 2: partial results for every lane size
    logic             s2_valid, s2_err;
    lmul_size_e       s2_size;
    lmul_op_e         s2_op;
    logic [PW-1:0]    s2_p16, s2_p32;
    logic [VEC_W-1:0] s2_p64;

    logic [PW-1:0]    c_p16, c_p32;
    logic [VEC_W-1:0] c_p64, c_data;
    logic             c_sgn;

    assign c_sgn = (s1_op == OP_HIGH_S);

    lmul_lane_array #(.VEC_W(VEC_W), .LW(16)) u_arr16 (
        .a(s1_a), .b(s1_b), .sgn(c_sgn), .prod(c_p16)
    );
    lmul_lane_array #(.VEC_W(VEC_W), .LW(32)) u_arr32 (
        .a(s1_a), .b(s1_b), .sgn(c_sgn), .prod(c_p32)
    );
    lmul_digit64 #(.VEC_W(VEC_W)) u_dig64 (
        .a(s1_a), .b(s1_b), .prod(c_p64)
    );
    lmul_select #(.VEC_W(VEC_W)) u_sel (
        .size(s2_size), .op(s2_op), .err(s2_err),
        .p16(s2_p16), .p32(s2_p32), .p64(s2_p64), .data(c_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid  <= 1'b0;
            s2_valid  <= 1'b0;
            out_valid <= 1'b0;
        end else if (adv) begin
            s1_valid  <= in_valid;
            s2_valid  <= s1_valid;
            out_valid <= s2_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (adv) begin
            s1_a     <= in_a;
            s1_b     <= in_b;
            s1_size  <= lmul_size_e'(in_size);
            s1_op    <= lmul_op_e'(in_op);
            s1_err   <= !lmul_legal(lmul_size_e'(in_size), lmul_op_e'(in_op));
            s2_size  <= s1_size;
            s2_op    <= s1_op;
            s2_err   <= s1_err;
            s2_p16   <= c_p16;
            s2_p32   <= c_p32;
            s2_p64   <= c_p64;
            out_data <= c_data;
            out_err  <= s2_err;
        end
    end

    // R8: a stalled result stays put
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_err));

    // R6: an error transfer carries no data
    p_err_zero_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_err |-> out_data == '0);

    // R7: an accepted transfer emerges after three advancing edges
    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && in_ready, 2) && $past(out_ready) && out_ready |=> out_valid);

    // R7: a bubble entering with ready high emerges as a bubble
    p_bubble_r7: assert property (@(posedge clk) disable iff (rst)
        $past(out_ready && !in_valid, 2) && $past(out_ready) && out_ready |=> !out_valid);

endmodule

// File: tb/sim_lmul_unit.sv
module sim_lmul_unit;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_a = '0, in_b = '0;
    logic [1:0]   in_size = '0, in_op = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_data;
    logic         out_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit rand_ready = 0;

    typedef struct {
        logic [128:0] v;
        logic [1:0]   sz;
        logic [1:0]   op;
    } exp_t;
    exp_t expq[$];

    always #2 clk = ~clk;

    lmul_unit u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_size(in_size), .in_op(in_op),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_err(out_err)
    );

    function automatic logic [128:0] ref_calc(input logic [127:0] a, input logic [127:0] b,
                                              input logic [1:0] sz, input logic [1:0] op);
        logic [127:0] r;
        logic         e;
        r = '0;
        e = (sz == 2'd3) || (sz == 2'd2 && op != 2'd0);
        if (!e && sz == 2'd2) begin
            for (int i = 0; i < 2; i++) r[i*64 +: 64] = a[i*64 +: 64] * b[i*64 +: 64];
        end else if (!e && sz == 2'd1) begin
            for (int i = 0; i < 4; i++) begin
                logic [63:0] x, y, p;
                x = {32'd0, a[i*32 +: 32]};
                y = {32'd0, b[i*32 +: 32]};
                if (op == 2'd2) begin
                    x[63:32] = {32{x[31]}};
                    y[63:32] = {32{y[31]}};
                end
                p = x * y;
                if (op == 2'd0) r[i*32 +: 32] = p[31:0];
                else if (op == 2'd3) begin
                    if (i % 2 == 0) r[(i/2)*64 +: 64] = p;
                end else r[i*32 +: 32] = p[63:32];
            end
        end else if (!e) begin
            for (int i = 0; i < 8; i++) begin
                logic [31:0] x, y, p;
                x = {16'd0, a[i*16 +: 16]};
                y = {16'd0, b[i*16 +: 16]};
                if (op == 2'd2) begin
                    x[31:16] = {16{x[15]}};
                    y[31:16] = {16{y[15]}};
                end
                p = x * y;
                if (op == 2'd0) r[i*16 +: 16] = p[15:0];
                else if (op == 2'd3) begin
                    if (i % 2 == 0) r[(i/2)*32 +: 32] = p;
                end else r[i*16 +: 16] = p[31:16];
            end
        end
        return {e, r};
    endfunction

    function automatic string req_of(input logic [1:0] sz, input logic [1:0] op);
        if (sz == 2'd3 || (sz == 2'd2 && op != 2'd0)) return "R6";
        if (sz == 2'd2) return "R2";
        case (op)
            2'd0: return "R1";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [128:0] act,
                         input logic [128:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // scoreboard and handshake monitor, sampled between edges
    bit           prev_stall = 0;
    logic [128:0] prev_out;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall)
                check(out_valid && {out_err, out_data} == prev_out, "R8",
                      {out_err, out_data}, prev_out);
            check(in_ready == out_ready, "R8", 129'(in_ready), 129'(out_ready));
            if (out_valid && out_ready) begin
                if (expq.size() == 0) check(0, "R7", {out_err, out_data}, '0);
                else begin
                    exp_t x;
                    x = expq.pop_front();
                    check({out_err, out_data} === x.v, req_of(x.sz, x.op),
                          {out_err, out_data}, x.v);
                end
            end
            if (in_valid && in_ready) begin
                exp_t n;
                n.v = ref_calc(in_a, in_b, in_size, in_op);
                n.sz = in_size;
                n.op = in_op;
                expq.push_back(n);
            end
            prev_stall = out_valid && !out_ready;
            prev_out   = {out_err, out_data};
        end
    end

    always begin
        @(posedge clk);
        #1;
        out_ready = rand_ready ? (($urandom % 10) < 7) : 1'b1;
    end

    // called just after a rising edge; returns just after the accepting edge
    task automatic send(input logic [127:0] a, input logic [127:0] b,
                        input logic [1:0] sz, input logic [1:0] op);
        in_a = a; in_b = b; in_size = sz; in_op = op; in_valid = 1'b1;
        do @(posedge clk); while (!in_ready);
        #1;
        in_valid = 1'b0;
    endtask

    function automatic logic [127:0] rnd128();
        logic [127:0] v;
        case ($urandom % 6)
            0: v = '1;
            1: v = '0;
            2: v = {4{32'h8000_0000}};
            default: v = {$urandom, $urandom, $urandom, $urandom};
        endcase
        return v;
    endfunction

    initial begin
        void'($urandom(32'h1e57_5eed));
        repeat (4) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R9", 129'(out_valid), '0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", 129'(out_valid), '0);

        // latency with ready held high
        @(posedge clk); #1;
        send({8{16'h0003}}, {8{16'h0005}}, 2'd0, 2'd0);
        @(negedge clk);
        check(!out_valid, "R7", 129'(out_valid), '0);
        @(negedge clk);
        check(!out_valid, "R7", 129'(out_valid), '0);
        @(negedge clk);
        check(out_valid, "R7", 129'(out_valid), 129'(1));

        // directed corners, all checked through the scoreboard
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++)
                send('1, '1, 2'(s), 2'(o));
        send({4{32'h8000_0000}}, {4{32'h8000_0000}}, 2'd1, 2'd2);
        send({8{16'h8000}}, {8{16'h7fff}}, 2'd0, 2'd2);
        // odd lanes differ, even lanes the same: widening must ignore odd lanes (R5)
        send({32'hdead_beef, 32'h0000_0002, 32'h1234_5678, 32'hffff_ffff},
             {32'h0bad_f00d, 32'h0000_0003, 32'h9abc_def0, 32'hffff_ffff}, 2'd1, 2'd3);
        send({32'h0000_0000, 32'h0000_0002, 32'h0000_0000, 32'hffff_ffff},
             {32'h0000_0000, 32'h0000_0003, 32'h0000_0000, 32'hffff_ffff}, 2'd1, 2'd3);
        send({64'hffff_ffff_0000_0001, 64'h0000_0001_ffff_ffff},
             {64'h0000_0002_0000_0003, 64'hffff_ffff_ffff_ffff}, 2'd2, 2'd0);

        // constrained random with stalls
        rand_ready = 1;
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] sz;
            sz = (($urandom % 16) == 0) ? 2'd3 : 2'($urandom % 3);
            send(rnd128(), rnd128(), sz, 2'($urandom % 4));
            repeat ($urandom % 3) begin
                @(posedge clk); #1;
            end
        end
        rand_ready = 0;
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(expq.size() == 0, "R7", 129'(expq.size()), '0);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R7 watchdog expired actual=running expected=finished");
        summary();
    end

endmodule